// File: doc/BRIEF.md
# Interrupt CALL Vector Sequencer

This block builds the 16-bit service-routine address for an acknowledged interrupt request and hands it to the processor as a three-byte CALL instruction. The instruction is spread over three acknowledge pulses. The high address byte comes straight from configuration.

The low address byte has two parts. Its upper bits come from configuration. The remaining bits are filled in by hardware from the active request level, using a spacing of either 4 or 8 bytes between neighbouring levels.

The request level is captured on the first pulse, so a change of the active level later in the sequence does not alter the address. After the third pulse ends, a single-cycle completion pulse goes out, which the priority logic can use to update its in-service state.

Top module: `vec_call_seq`

## Requirements
- R1: After reset, `dataOut` is 00h, `driveEn` is 0 and `seqDone` is 0, and the next acknowledge pulse is treated as the first of a sequence.
- R2: `driveEn` is 1 exactly in the cycles where `ackIn` is 1.
- R3: During the first acknowledge pulse of a sequence, `dataOut` is CDh.
- R4: With `gap4` = 1 (4-byte spacing), the second pulse drives the low byte {`addrLowCfg[7:5]`, level, 2'b00}. For example, a high byte of 62h, a low setting of 80h and level 0 give the address 6280h.
- R5: With `gap4` = 0 (8-byte spacing), the second pulse drives the low byte {`addrLowCfg[7:6]`, level, 3'b000}.
- R6: During the third pulse, `dataOut` equals `addrHighCfg`.
- R7: The level on `irLevel` is captured in the first clock cycle of the first pulse. Any value `irLevel` takes after that has no effect on the low byte of that sequence.
- R8: `seqDone` is 1 for exactly one cycle, in the cycle after the first low cycle that follows the third pulse. The next pulse then starts a new sequence with CDh.
- R9: While `driveEn` is 0, `dataOut` is 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irLevel | input | 3 | Level of the request being acknowledged |
| gap4 | input | 1 | 1 = 4-byte vector spacing, 0 = 8-byte spacing |
| addrLowCfg | input | 8 | Configured low address byte; bits 7:5 or 7:6 are used |
| addrHighCfg | input | 8 | Configured high address byte |
| ackIn | input | 1 | Acknowledge pulse, active high, lasting one or more cycles |
| dataOut | output | 8 | Byte for the data bus |
| driveEn | output | 1 | Data bus drive enable |
| seqDone | output | 1 | One-cycle pulse after the third byte |

## Verification
The bench sweeps all eight levels under both spacings. It uses low settings whose upper bits are all zeros, all ones, or alternating, so a wrong field boundary between the configured bits and the inserted level bits shows up as a wrong byte. Two high bytes with different bit patterns separate the third byte from the low byte and from the opcode.

In every sequence the level input is changed to its bitwise inverse after the first pulse, which separates a captured level from a live one. The bench also checks the bus between pulses and the completion pulse on both sides of its single cycle. This catches any output leaking outside a pulse and any step in the byte order.

// File: rtl/vec_call_pkg.sv
package vec_call_pkg;
  localparam int LEVEL_W = 3;
  localparam int BYTE_W  = 8;
  localparam int IDX_W   = 2;
  localparam logic [BYTE_W-1:0] CALL_OP = 8'hCD;

  typedef enum logic [IDX_W-1:0] {
    BYTE_OP   = 2'd0,
    BYTE_LOW  = 2'd1,
    BYTE_HIGH = 2'd2
  } byteSel_e;

  typedef struct packed {
    logic     latchLevel;
    logic     drive;
    byteSel_e byteSel;
  } vecCtrl_t;
endpackage

// File: rtl/vec_call_ctrl.sv
module vec_call_ctrl
  import vec_call_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     ackIn,
  output vecCtrl_t ctrl,
  output logic     seqDone
);
  logic     ackPrev;
  byteSel_e idx;
  logic     ackRise;
  logic     ackFall;

  assign ackRise = ackIn && !ackPrev;
  assign ackFall = !ackIn && ackPrev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ackPrev <= 1'b0;
      idx     <= BYTE_OP;
      seqDone <= 1'b0;
    end else begin
      ackPrev <= ackIn;
      seqDone <= ackFall && (idx == BYTE_HIGH);
      if (ackFall) begin
        unique case (idx)
          BYTE_OP:  idx <= BYTE_LOW;
          BYTE_LOW: idx <= BYTE_HIGH;
          default:  idx <= BYTE_OP;
        endcase
      end
    end
  end

  always_comb begin
    ctrl.latchLevel = ackRise && (idx == BYTE_OP);
    ctrl.drive      = ackIn;
    ctrl.byteSel    = idx;
  end
endmodule

// File: rtl/vec_call_dp.sv
module vec_call_dp
  import vec_call_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  vecCtrl_t           ctrl,
  input  logic [LEVEL_W-1:0] irLevel,
  input  logic               gap4,
  input  logic [BYTE_W-1:0]  addrLowCfg,
  input  logic [BYTE_W-1:0]  addrHighCfg,
  output logic [BYTE_W-1:0]  dataOut
);
  localparam int FIX4_W = BYTE_W - LEVEL_W - 2;
  localparam int FIX8_W = BYTE_W - LEVEL_W - 3;

  logic [LEVEL_W-1:0] levelHeld;
  logic [BYTE_W-1:0]  lowByte;
  logic [BYTE_W-1:0]  selByte;

  always_ff @(posedge clk) begin
    if (!rst_n) levelHeld <= '0;
    else if (ctrl.latchLevel) levelHeld <= irLevel;
  end

  always_comb begin
    if (gap4)
      lowByte = {addrLowCfg[BYTE_W-1 -: FIX4_W], levelHeld, 2'b00};
    else
      lowByte = {addrLowCfg[BYTE_W-1 -: FIX8_W], levelHeld, 3'b000};
  end

  always_comb begin
    unique case (ctrl.byteSel)
      BYTE_OP:   selByte = CALL_OP;
      BYTE_LOW:  selByte = lowByte;
      BYTE_HIGH: selByte = addrHighCfg;
      default:   selByte = '0;
    endcase
    dataOut = ctrl.drive ? selByte : '0;
  end
endmodule

// File: rtl/vec_call_seq.sv
module vec_call_seq
  import vec_call_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] irLevel,
  input  logic       gap4,
  input  logic [7:0] addrLowCfg,
  input  logic [7:0] addrHighCfg,
  input  logic       ackIn,
  output logic [7:0] dataOut,
  output logic       driveEn,
  output logic       seqDone
);
  vecCtrl_t ctrl;

  vec_call_ctrl ctrl_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .ackIn   (ackIn),
    .ctrl    (ctrl),
    .seqDone (seqDone)
  );

  vec_call_dp dp_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctrl        (ctrl),
    .irLevel     (irLevel),
    .gap4        (gap4),
    .addrLowCfg  (addrLowCfg),
    .addrHighCfg (addrHighCfg),
    .dataOut     (dataOut)
  );

  assign driveEn = ctrl.drive;
endmodule

// File: rtl/vec_call_seq_chk.sv
module vec_call_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ackIn,
  input logic [7:0] addrHighCfg,
  input logic [7:0] dataOut,
  input logic       driveEn,
  input logic       seqDone
);
  // R9
  bus_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !driveEn |-> dataOut == 8'h00);

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seqDone |=> !seqDone);

  // R6
  done_after_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(seqDone) |-> (!$past(ackIn) && $past(ackIn, 2)
                        && $past(dataOut, 2) == $past(addrHighCfg, 2)));

  // R2
  drive_on_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ackIn) |-> driveEn);
endmodule

bind vec_call_seq vec_call_seq_chk chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .ackIn       (ackIn),
  .addrHighCfg (addrHighCfg),
  .dataOut     (dataOut),
  .driveEn     (driveEn),
  .seqDone     (seqDone)
);

// File: tb/vec_call_seq_tb.sv
module vec_call_seq_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] irLevel = '0;
  logic       gap4 = 1'b1;
  logic [7:0] addrLowCfg = '0;
  logic [7:0] addrHighCfg = '0;
  logic       ackIn = 1'b0;
  logic [7:0] dataOut;
  logic       driveEn;
  logic       seqDone;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  vec_call_seq dut_i (
    .clk(clk), .rst_n(rst_n), .irLevel(irLevel), .gap4(gap4),
    .addrLowCfg(addrLowCfg), .addrHighCfg(addrHighCfg), .ackIn(ackIn),
    .dataOut(dataOut), .driveEn(driveEn), .seqDone(seqDone)
  );

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, actual, expected);
    end
  endtask

  // one acknowledge pulse of two cycles; returns the byte seen during it
  task automatic pulse(output logic [7:0] seen, output logic en);
    @(negedge clk);
    ackIn = 1'b1;
    #1;
    seen = dataOut;
    en = driveEn;
    @(negedge clk);
    @(negedge clk);
    ackIn = 1'b0;
    #1;
  endtask

  initial begin
    logic [7:0] b;
    logic e;
    logic [7:0] lows [3] = '{8'h00, 8'hE0, 8'hA0};
    logic [7:0] highs [2] = '{8'h62, 8'h9D};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 dataOut", dataOut, 0);
    check("R1 driveEn", driveEn, 0);
    check("R1 seqDone", seqDone, 0);
    // worked example: 6280h with 4-byte spacing, level 0
    gap4 = 1'b1; addrLowCfg = 8'h80; addrHighCfg = 8'h62; irLevel = 3'd0;
    pulse(b, e); check("R1 R3 first byte", b, 8'hCD);
    pulse(b, e); check("R4 example low", b, 8'h80);
    pulse(b, e); check("R6 example high", b, 8'h62);
    @(negedge clk); check("R8 done", seqDone, 1);
    @(negedge clk); check("R8 done once", seqDone, 0);
    for (int g = 0; g < 2; g++) begin
      for (int lv = 0; lv < 8; lv++) begin
        for (int c = 0; c < 3; c++) begin
          logic [7:0] expLow;
          gap4 = g[0];
          addrLowCfg = lows[c];
          addrHighCfg = highs[(lv + c) % 2];
          irLevel = lv[2:0];
          expLow = g[0] ? ((lows[c] & 8'hE0) | (lv * 4)) : ((lows[c] & 8'hC0) | (lv * 8));
          pulse(b, e);
          check("R3 opcode", b, 8'hCD);
          check("R2 drive on pulse", e, 1);
          check("R9 idle bus", dataOut, 0);
          check("R2 drive off", driveEn, 0);
          irLevel = ~lv[2:0];  // R7: must not matter
          pulse(b, e);
          if (g != 0) check("R4 R7 low byte 4-spacing", b, expLow);
          else check("R5 R7 low byte 8-spacing", b, expLow);
          check("R8 no early done", seqDone, 0);
          pulse(b, e);
          check("R6 high byte", b, addrHighCfg);
          @(negedge clk); check("R8 done pulse", seqDone, 1);
          @(negedge clk); check("R8 done ends", seqDone, 0);
        end
      end
    end
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule